// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller Sequencer

This block sits between a simple 32-bit register bus and a one-time-programmable fuse array. Software points the controller at one fuse word by bank and word number, then either senses that word into a read-back register or burns a new value into it. Burning is refused unless a 16-bit unlock key sits in the control word, and the key is dropped once a burn finishes, so every burn needs its own unlock.

Every operation is a timed sequence of three phases: a relax interval, an active strobe, and a second relax interval. The lengths come from a timing register that software loads in clock cycles. The strobe fields already include both relax intervals, so the whole operation lasts the strobe field plus one cycle. If the strobe field is too short to cover both relax intervals, the active strobe is held at one cycle. The fuse array is modelled inside the block as 128 words of flops in which bits can only be set. After reset the array holds a fixed image chosen by parameters.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset, the control register (offset 0), the timing register (offset 2), the program-data register (offset 4) and the read-data register (offset 5) all read as zero.
- R2: A write to the control register stores the unlock field in bits 31:16 and the word address in bits 6:0, which is {bank[3:0], word[2:0]} and selects word index bank*8+word. Bits 8 (busy) and 9 (error) cannot be written there, and every other bit reads zero.
- R3: The timing register keeps the program strobe in bits 11:0, the relax count in bits 15:12 and the read strobe in bits 21:16. Bits 31:22 read zero.
- R4: Writing a value with bit 0 set to offset 3 starts a sense of the addressed word. Once busy falls, offset 5 holds that word. Writing offset 3 with bit 0 clear starts nothing.
- R5: A sense keeps busy (control bit 8) high for max(RS+1, 2*RX+3) cycles after the starting write edge, where RS is the read strobe field and RX is the relax field.
- R6: A program operation keeps busy high for max(PS+1, 2*RX+3) cycles, where PS is the program strobe field.
- R7: Writing offset 4 while the unlock field equals 16'h3E77 programs the addressed word. The stored word becomes the old word OR the written data.
- R8: The unlock field reads zero once a program operation completes.
- R9: Writing offset 4 without the key sets the error flag (control bit 9), does not raise busy and leaves the array unchanged.
- R10: A start request made while busy is high sets the error flag and is dropped. The operation already running finishes on the address it latched at its start.
- R11: Writing offset 1 with bit 9 set clears the error flag. Writing offset 1 with bit 9 clear leaves it unchanged.
- R12: After reset, with preload enabled, word i holds SEED ^ (i * 32'h9E3779B9), truncated to 32 bits. With preload disabled, every word holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word offset |
| rd_data | output | 32 | Read data for the offset on rd_addr (combinational) |

## Verification
The bench measures how long busy stays high at both extremes of the timing fields: a short strobe with a long relax, where a design without the one-cycle clamp would wrap its counter and stay busy for thousands of cycles, and the largest program strobe, where an off-by-one appears as a duration one cycle wrong. It moves the address and issues a second start in the middle of a sense. A design that failed to latch the address, or that accepted the second start, would return the wrong word or miss the error. It also checks that burns only OR bits in, and that a keyless burn neither raises busy nor changes the word. A design that overwrote words or ignored the key would show the wrong value on the next sense.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;

    localparam logic [2:0] OFS_CTRL   = 3'd0;
    localparam logic [2:0] OFS_CLR    = 3'd1;
    localparam logic [2:0] OFS_TIMING = 3'd2;
    localparam logic [2:0] OFS_RCTL   = 3'd3;
    localparam logic [2:0] OFS_PDATA  = 3'd4;
    localparam logic [2:0] OFS_RDATA  = 3'd5;

    localparam logic [15:0] UNLOCK_KEY = 16'h3E77;
    localparam int UNLOCK_LSB   = 16;
    localparam int BUSY_BIT     = 8;
    localparam int ERR_BIT      = 9;
    localparam int TM_RELAX_LSB = 12;
    localparam int TM_READ_LSB  = 16;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_STRB = 2'd2,
        PH_POST = 2'd3
    } phase_e;

    // power-up image of one fuse word
    function automatic logic [31:0] preload_word(input logic [31:0] seed, input int idx);
        logic [31:0] mix;
        mix = 32'(idx) * 32'h9E3779B9;
        return seed ^ mix;
    endfunction

endpackage

// File: rtl/otp_phase_timer.sv
module otp_phase_timer
    import otp_fuse_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int RELAX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [RELAX_W-1:0] relax_i,
    input  logic [CNT_W-1:0]   field_i,
    output logic               busy_o,
    output logic               done_o
);

    localparam int EXT_W = CNT_W + 1;

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   slen;
        logic [RELAX_W-1:0] rlx;
    } tstate_t;

    tstate_t t_d, t_q;
    logic [EXT_W-1:0] twice_relax;
    logic [EXT_W-1:0] fld_ext;
    logic [EXT_W-1:0] strobe_raw;
    logic [CNT_W-1:0] strobe_len;

    // the field holds both relax periods; what is left is the strobe, at least one cycle
    always_comb begin
        twice_relax = {{(CNT_W-RELAX_W){1'b0}}, relax_i, 1'b0} + EXT_W'(2);
        fld_ext     = {1'b0, field_i};
        strobe_raw  = fld_ext - twice_relax + EXT_W'(1);
        strobe_len  = (fld_ext >= twice_relax) ? strobe_raw[CNT_W-1:0] : CNT_W'(1);
    end

    always_comb begin
        t_d = t_q;
        unique case (t_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    t_d.phase = PH_PRE;
                    t_d.cnt   = CNT_W'(relax_i);
                    t_d.rlx   = relax_i;
                    t_d.slen  = strobe_len;
                end
            end
            PH_PRE: begin
                if (t_q.cnt == '0) begin
                    t_d.phase = PH_STRB;
                    t_d.cnt   = t_q.slen - CNT_W'(1);
                end else begin
                    t_d.cnt = t_q.cnt - CNT_W'(1);
                end
            end
            PH_STRB: begin
                if (t_q.cnt == '0) begin
                    t_d.phase = PH_POST;
                    t_d.cnt   = CNT_W'(t_q.rlx);
                end else begin
                    t_d.cnt = t_q.cnt - CNT_W'(1);
                end
            end
            default: begin
                if (t_q.cnt == '0) begin
                    t_d.phase = PH_IDLE;
                end else begin
                    t_d.cnt = t_q.cnt - CNT_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '{phase: PH_IDLE, cnt: '0, slen: '0, rlx: '0};
        end else begin
            t_q <= t_d;
        end
    end

    assign busy_o = (t_q.phase != PH_IDLE);
    assign done_o = (t_q.phase == PH_POST) && (t_q.cnt == '0);

    // R5
    strobe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.phase == PH_STRB) |-> (t_q.cnt < t_q.slen));

    // R5
    busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
    import otp_fuse_pkg::*;
#(
    parameter int          NWORDS       = 128,
    parameter int          AW           = 7,
    parameter int          DW           = 32,
    parameter bit          PRELOAD_EN   = 1'b0,
    parameter logic [31:0] PRELOAD_SEED = 32'h0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    logic [DW-1:0] mem_d [NWORDS];
    logic [DW-1:0] mem_q [NWORDS];

    // a burn can only set bits
    always_comb begin
        for (int i = 0; i < NWORDS; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we_i) begin
            mem_d[waddr_i] = mem_q[waddr_i] | wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) begin
                mem_q[i] <= PRELOAD_EN ? DW'(preload_word(PRELOAD_SEED, i)) : '0;
            end
        end else begin
            for (int i = 0; i < NWORDS; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata_o = mem_q[raddr_i];

    // R7
    burn_sets_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> ((mem_q[$past(waddr_i)] & $past(wdata_i)) == $past(wdata_i)));

    // R7
    burn_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> ((mem_q[$past(waddr_i)] & $past(mem_q[waddr_i])) == $past(mem_q[waddr_i])));

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
    import otp_fuse_pkg::*;
#(
    parameter int          BANKS        = 16,
    parameter int          WORDS        = 8,
    parameter int          PROG_W       = 12,
    parameter int          RELAX_W      = 4,
    parameter int          READ_W       = 6,
    parameter bit          PRELOAD_EN   = 1'b0,
    parameter logic [31:0] PRELOAD_SEED = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [2:0]  rd_addr,
    output logic [31:0] rd_data
);

    localparam int NWORDS = BANKS * WORDS;
    localparam int AW     = $clog2(NWORDS);
    localparam int DW     = 32;

    typedef struct packed {
        logic [15:0]        unlock;
        logic [AW-1:0]      addr;
        logic               err;
        logic [PROG_W-1:0]  t_prog;
        logic [RELAX_W-1:0] t_relax;
        logic [READ_W-1:0]  t_read;
        logic [DW-1:0]      rdata;
        logic [DW-1:0]      pdata;
        logic               op_prog;
        logic [AW-1:0]      op_addr;
    } regs_t;

    regs_t r_d, r_q;

    logic busy, done;
    logic sense_req, prog_req, key_ok;
    logic start_sense, start_prog, err_set;
    logic arr_we;
    logic [DW-1:0] arr_rdata;
    logic [PROG_W-1:0] tm_field;

    otp_phase_timer #(
        .CNT_W  (PROG_W),
        .RELAX_W(RELAX_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_sense | start_prog),
        .relax_i(r_q.t_relax),
        .field_i(tm_field),
        .busy_o (busy),
        .done_o (done)
    );

    otp_fuse_array #(
        .NWORDS      (NWORDS),
        .AW          (AW),
        .DW          (DW),
        .PRELOAD_EN  (PRELOAD_EN),
        .PRELOAD_SEED(PRELOAD_SEED)
    ) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (arr_we),
        .waddr_i(r_q.op_addr),
        .wdata_i(r_q.pdata),
        .raddr_i(r_q.op_addr),
        .rdata_o(arr_rdata)
    );

    always_comb begin
        r_d         = r_q;
        sense_req   = wr_en && (wr_addr == OFS_RCTL) && wr_data[0];
        prog_req    = wr_en && (wr_addr == OFS_PDATA);
        key_ok      = (r_q.unlock == UNLOCK_KEY);
        start_sense = sense_req && !busy;
        start_prog  = prog_req && !busy && key_ok;
        err_set     = ((sense_req || prog_req) && busy) || (prog_req && !key_ok);
        tm_field    = start_prog ? r_q.t_prog : {{(PROG_W-READ_W){1'b0}}, r_q.t_read};

        if (wr_en && (wr_addr == OFS_CTRL)) begin
            r_d.unlock = wr_data[UNLOCK_LSB +: 16];
            r_d.addr   = wr_data[AW-1:0];
        end
        if (wr_en && (wr_addr == OFS_TIMING)) begin
            r_d.t_prog  = wr_data[PROG_W-1:0];
            r_d.t_relax = wr_data[TM_RELAX_LSB +: RELAX_W];
            r_d.t_read  = wr_data[TM_READ_LSB +: READ_W];
        end
        // clear first so a same-cycle set wins
        if (wr_en && (wr_addr == OFS_CLR) && wr_data[ERR_BIT]) begin
            r_d.err = 1'b0;
        end
        if (err_set) begin
            r_d.err = 1'b1;
        end

        if (start_sense || start_prog) begin
            r_d.op_prog = start_prog;
            r_d.op_addr = r_q.addr;
        end
        if (start_prog) begin
            r_d.pdata = wr_data;
        end

        arr_we = done && r_q.op_prog;
        if (done && !r_q.op_prog) begin
            r_d.rdata = arr_rdata;
        end
        if (arr_we) begin
            r_d.unlock = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            OFS_CTRL: begin
                rd_data[UNLOCK_LSB +: 16] = r_q.unlock;
                rd_data[ERR_BIT]          = r_q.err;
                rd_data[BUSY_BIT]         = busy;
                rd_data[AW-1:0]           = r_q.addr;
            end
            OFS_TIMING: begin
                rd_data[PROG_W-1:0]                = r_q.t_prog;
                rd_data[TM_RELAX_LSB +: RELAX_W]   = r_q.t_relax;
                rd_data[TM_READ_LSB +: READ_W]     = r_q.t_read;
            end
            OFS_PDATA: rd_data = r_q.pdata;
            OFS_RDATA: rd_data = r_q.rdata;
            default:   rd_data = '0;
        endcase
    end

    // R8
    unlock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_q.op_prog) |=> (r_q.unlock == '0));

    // R9
    keyless_burn_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req && !key_ok) |=> (r_q.err && !$rose(busy)));

    // R10
    busy_start_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sense_req || prog_req) && busy) |=> r_q.err);

    // R11
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == OFS_CLR) && wr_data[ERR_BIT] && !err_set) |=> !r_q.err);

endmodule

// File: tb/otp_fuse_ctrl_test.sv
`timescale 1ns/1ps
module otp_fuse_ctrl_test;

    localparam logic [31:0] SEED = 32'hA5A5_0F0F;
    localparam logic [15:0] KEY  = 16'h3E77;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [31:0] model [128];
    logic [3:0]  cur_rx = '0;
    logic [5:0]  cur_rs = '0;
    logic [11:0] cur_ps = '0;

    always #2 clk = ~clk;

    otp_fuse_ctrl #(.PRELOAD_EN(1'b1), .PRELOAD_SEED(SEED)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic int exp_dur(input int field, input int rx);
        return (field + 1 > 2 * rx + 3) ? field + 1 : 2 * rx + 3;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_idle(output int n);
        logic [31:0] c;
        n = 0;
        rd(3'd0, c);
        while (c[8] && n < 20000) begin
            @(negedge clk);
            n++;
            rd(3'd0, c);
        end
    endtask

    task automatic set_timing(input logic [5:0] rs, input logic [3:0] rx, input logic [11:0] ps);
        cur_rs = rs; cur_rx = rx; cur_ps = ps;
        wr(3'd2, {10'h3FF, rs, rx, ps});
    endtask

    task automatic sense(input int idx, input string tag);
        int n;
        logic [31:0] d;
        wr(3'd0, 32'(idx));
        wr(3'd3, 32'h1);
        wait_idle(n);
        chk(n == exp_dur(cur_rs, cur_rx), "R5 sense duration", 32'(n), 32'(exp_dur(cur_rs, cur_rx)));
        rd(3'd5, d);
        chk(d == model[idx], tag, d, model[idx]);
    endtask

    task automatic burn(input int idx, input logic [31:0] v);
        int n;
        logic [31:0] c;
        wr(3'd0, {KEY, 9'd0, 7'(idx)});
        wr(3'd4, v);
        wait_idle(n);
        chk(n == exp_dur(cur_ps, cur_rx), "R6 program duration", 32'(n), 32'(exp_dur(cur_ps, cur_rx)));
        model[idx] = model[idx] | v;
        rd(3'd0, c);
        chk(c[31:16] == 16'h0, "R8 unlock cleared", {16'h0, c[31:16]}, 32'h0);
        sense(idx, "R7 burned word ORs in data");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n;
        void'($urandom(32'd7));
        for (int i = 0; i < 128; i++) model[i] = SEED ^ (32'(i) * 32'h9E3779B9);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, d); chk(d == 32'h0, "R1 control reset", d, 32'h0);
        rd(3'd2, d); chk(d == 32'h0, "R1 timing reset", d, 32'h0);
        rd(3'd4, d); chk(d == 32'h0, "R1 program data reset", d, 32'h0);
        rd(3'd5, d); chk(d == 32'h0, "R1 read data reset", d, 32'h0);

        // R12 preload image, default timing (3-cycle operations)
        sense(0,   "R12 preload word 0");
        sense(127, "R12 preload word 127");
        sense(37,  "R4 R12 preload word 37");

        // R4 bit0 clear starts nothing
        wr(3'd0, 32'd50);
        wr(3'd3, 32'hFFFF_FFFE);
        rd(3'd0, d); chk(d[8] == 1'b0, "R4 no start without bit0", {31'd0, d[8]}, 32'h0);
        rd(3'd5, d); chk(d == model[37], "R4 read data kept", d, model[37]);

        // R2 control write masking
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, d); chk(d == 32'hFFFF_007F, "R2 control readback", d, 32'hFFFF_007F);
        wr(3'd0, 32'h0);

        // R3 timing packing
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, d); chk(d == 32'h003F_FFFF, "R3 timing readback", d, 32'h003F_FFFF);
        wr(3'd2, 32'h0012_3456);
        rd(3'd2, d); chk(d == 32'h0012_3456, "R3 timing fields", d, 32'h0012_3456);

        // R9 keyless and wrong-key burns
        set_timing(6'd10, 4'd1, 12'd20);
        wr(3'd0, 32'd5);
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd0, d); chk(d[9:8] == 2'b10, "R9 keyless burn flags", {30'd0, d[9:8]}, 32'h2);
        sense(5, "R9 word unchanged after keyless burn");
        wr(3'd1, 32'h200);
        wr(3'd0, {16'h3E76, 16'd5});
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd0, d); chk(d[9:8] == 2'b10, "R9 wrong key flags", {30'd0, d[9:8]}, 32'h2);
        sense(5, "R9 word unchanged after wrong key");

        // R11 error clear alias
        wr(3'd1, 32'hFFFF_FDFF);
        rd(3'd0, d); chk(d[9] == 1'b1, "R11 clear without bit9", {31'd0, d[9]}, 32'h1);
        wr(3'd1, 32'h200);
        rd(3'd0, d); chk(d[9] == 1'b0, "R11 clear with bit9", {31'd0, d[9]}, 32'h0);

        // R10 second start during a sense, address moved mid-operation
        set_timing(6'd40, 4'd3, 12'd30);
        wr(3'd0, 32'd10);
        wr(3'd3, 32'h1);
        wr(3'd0, {KEY, 16'd20});
        wr(3'd3, 32'h1);
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd0, d); chk(d[9] == 1'b1, "R10 error on busy start", {31'd0, d[9]}, 32'h1);
        wait_idle(n);
        rd(3'd5, d); chk(d == model[10], "R10 running sense keeps latched address", d, model[10]);
        rd(3'd0, d); chk(d[31:16] == KEY && d[6:0] == 7'd20, "R10 control kept key and new address", d, {KEY, 16'd20});
        wr(3'd1, 32'h200);
        wr(3'd0, 32'h0);
        sense(20, "R10 dropped burn left word unchanged");

        // R5 clamp: strobe shorter than both relax periods
        set_timing(6'd5, 4'd15, 12'd3);
        sense(77, "R5 clamped sense data");
        // R6 longest program strobe and clamp
        burn(9, 32'h0000_00F0);
        set_timing(6'd0, 4'd0, 12'd4095);
        burn(9, 32'h0F00_0000);

        // random mix
        for (int it = 0; it < 40; it++) begin
            int idx;
            idx = int'($urandom % 128);
            set_timing(6'($urandom), 4'($urandom), 12'($urandom % 300));
            if ($urandom % 2 == 0) burn(idx, $urandom & $urandom & $urandom);
            else sense(idx, "R4 random sense data");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule